// File: doc/BRIEF.md
# Second Operand Shifter Unit

This block builds the second source operand of a 32-bit data-processing datapath. It receives either a compact encoded immediate or a register value. A register value also comes with a shift kind and a shift amount. The block returns the finished operand together with a shifter carry. The flag update logic uses that carry whenever an operation asks for a flag write, so the carry is always valid.

Immediates are stored as an 8-bit constant plus a 4-bit rotate count. The constant is rotated right by twice that count. Register operands pass through a barrel shifter. The shift amount comes either from a 5-bit instruction field or from the low byte of a second register, and a mode input picks between the two. The unit is purely combinational. The carry-in comes from the current flag state.

Top module: `second_operand_shifter`

## Requirements
- R1: When `immSel` is 1, `operand` equals `immVal` zero-extended to 32 bits and rotated right by 2×`rotField` positions (0 to 30). In this mode the register, shift-kind and amount inputs have no effect.
- R2: For an expanded immediate, `carryOut` is bit 31 of `operand` when `rotField` is nonzero, and `carryIn` otherwise.
- R3: `shType` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For amounts 1 to 31, `carryOut` is the last bit shifted out (for example, 5 shifted left by 3 gives 40).
- R4: With an instruction amount (`amtFromReg` = 0), a logical left shift with `amtField` = 0 passes `regVal` and `carryIn` through unchanged.
- R5: With an instruction amount, logical right and arithmetic right with `amtField` = 0 act as shifts by 32. Logical right gives 0. Arithmetic right fills every bit with bit 31. In both cases `carryOut` is bit 31 of `regVal`.
- R6: With an instruction amount, rotate right with `amtField` = 0 rotates right by one through the carry. `operand` = {`carryIn`, `regVal`[31:1]} and `carryOut` = `regVal`[0].
- R7: With a register amount (`amtFromReg` = 1), the amount is the 8-bit `amtByte`, and any value up to 255 is honoured. `amtField` has no effect in this mode.
- R8: A register amount of 0 leaves `operand` = `regVal` and `carryOut` = `carryIn` for every shift kind.
- R9: A register amount of exactly 32 gives a logical result of 0. The carry is bit 0 of `regVal` for a left shift and bit 31 for a right shift. Amounts above 32 give 0 with carry 0.
- R10: A register amount of 32 or more on an arithmetic right shift fills every bit with bit 31 of `regVal`, and `carryOut` equals that bit.
- R11: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 leaves `operand` = `regVal`, with `carryOut` = bit 31 of `regVal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| immSel | input | 1 | 1 selects the expanded immediate, 0 selects the shifted register |
| immVal | input | 8 | Immediate constant before rotation |
| rotField | input | 4 | Immediate rotate count; the rotation applied is twice this value |
| regVal | input | 32 | Register operand to be shifted |
| shType | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amtFromReg | input | 1 | 1 takes the amount from `amtByte`, 0 takes it from `amtField` |
| amtField | input | 5 | Shift amount encoded in the instruction |
| amtByte | input | 8 | Low byte of the register that holds the shift amount |
| carryIn | input | 1 | Current carry flag |
| operand | output | 32 | Finished second operand |
| carryOut | output | 1 | Shifter carry for the flag logic |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width, an 8-bit immediate, a 4-bit rotate field, a 5-bit amount field and an 8-bit register amount. With these values a register amount can reach 255, which is well beyond the data width. That range brings the exact-32, above-32 and modulo-32 rotate corners into reach alongside the ordinary 1 to 31 range. A bit-serial reference model predicts every result, and random stimulus sweeps all shift kinds, both amount sources and both operand sources.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shKind_t;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic    doImm;    // expand the immediate
    logic    keep;     // pass register and carry unchanged
    logic    rrx;      // rotate by one through carry
    logic    big;      // amount of data width or more
    logic    exact;    // amount equals data width
    logic    rorFull;  // rotate by a nonzero multiple of the width
    shKind_t kind;
  } shCtrl_t;

endpackage

// File: rtl/opshift_ctrl.sv
module opshift_ctrl
  import opshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 5,
  parameter int REG_AMT_W = 8
) (
  input  logic                 immSel,
  input  logic                 amtFromReg,
  input  logic [1:0]           shType,
  input  logic [AMT_W-1:0]     amtField,
  input  logic [REG_AMT_W-1:0] amtByte,
  output shCtrl_t              ctl,
  output logic [AMT_W-1:0]     amt
);

  localparam logic [REG_AMT_W-1:0] WIDTH_AMT = REG_AMT_W'(DATA_W);

  always_comb begin
    ctl       = '0;
    ctl.kind  = shKind_t'(shType);
    ctl.doImm = immSel;
    amt       = amtField;
    if (!amtFromReg) begin
      if (amtField == '0) begin
        unique case (ctl.kind)
          SH_LSL:         ctl.keep = 1'b1;
          SH_LSR, SH_ASR: begin ctl.big = 1'b1; ctl.exact = 1'b1; end
          default:        ctl.rrx = 1'b1;
        endcase
      end
    end else begin
      amt = amtByte[AMT_W-1:0];
      if (amtByte == '0) begin
        ctl.keep = 1'b1;
      end else if (ctl.kind == SH_ROR) begin
        ctl.rorFull = (amtByte[AMT_W-1:0] == '0);
      end else if (amtByte >= WIDTH_AMT) begin
        ctl.big   = 1'b1;
        ctl.exact = (amtByte == WIDTH_AMT);
      end
    end
  end

  // R8: a zero register amount must never reach the shifter as a real shift
  always_comb begin
    if (amtFromReg && amtByte == '0)
      a_r8_zero_keeps : assert (ctl.keep && !ctl.big && !ctl.rorFull);
  end

endmodule

// File: rtl/opshift_dp.sv
module opshift_dp
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 5
) (
  input  shCtrl_t           ctl,
  input  logic [AMT_W-1:0]  amt,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [ROT_W-1:0]  rotField,
  input  logic [DATA_W-1:0] regVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] immExt, immRes, rorRes;
  logic [ROT_W:0]    immRot;
  logic [DATA_W:0]   lslW, lsrW, asrW;

  assign immExt = {{(DATA_W-IMM_W){1'b0}}, immVal};
  assign immRot = {rotField, 1'b0};
  assign immRes = (immExt >> immRot) | (immExt << (DATA_W - int'(immRot)));

  assign lslW   = {1'b0, regVal} << amt;
  assign lsrW   = {regVal, 1'b0} >> amt;
  assign asrW   = $signed({regVal, 1'b0}) >>> amt;
  assign rorRes = (regVal >> amt) | (regVal << (DATA_W - int'(amt)));

  always_comb begin
    operand  = regVal;
    carryOut = carryIn;
    if (ctl.doImm) begin
      operand  = immRes;
      carryOut = (rotField != '0) ? immRes[MSB] : carryIn;
    end else if (ctl.keep) begin
      operand  = regVal;
    end else if (ctl.rrx) begin
      operand  = {carryIn, regVal[MSB:1]};
      carryOut = regVal[0];
    end else if (ctl.rorFull) begin
      carryOut = regVal[MSB];
    end else if (ctl.big) begin
      unique case (ctl.kind)
        SH_LSL: begin operand = '0; carryOut = ctl.exact & regVal[0];   end
        SH_LSR: begin operand = '0; carryOut = ctl.exact & regVal[MSB]; end
        SH_ASR: begin operand = {DATA_W{regVal[MSB]}}; carryOut = regVal[MSB]; end
        default: operand = regVal;
      endcase
    end else begin
      unique case (ctl.kind)
        SH_LSL:  begin operand = lslW[DATA_W-1:0]; carryOut = lslW[DATA_W]; end
        SH_LSR:  begin operand = lsrW[DATA_W:1];   carryOut = lsrW[0];      end
        SH_ASR:  begin operand = asrW[DATA_W:1];   carryOut = asrW[0];      end
        default: begin operand = rorRes;           carryOut = rorRes[MSB];  end
      endcase
    end
  end

  // R1: no rotation leaves the constant in the low bits
  always_comb begin
    if (ctl.doImm && rotField == '0)
      a_r1_imm_unrotated : assert (operand == immExt);
  end

  // R6: rotate through carry moves the old carry to the top
  always_comb begin
    if (!ctl.doImm && ctl.rrx)
      a_r6_rrx_carry : assert (operand[MSB] == carryIn && carryOut == regVal[0]);
  end

  // R10: saturated arithmetic shift is all sign bits
  always_comb begin
    if (!ctl.doImm && ctl.big && ctl.kind == SH_ASR)
      a_r10_sign_fill : assert ($countones(operand) == 0 || $countones(operand) == DATA_W);
  end

  // R9: left shift beyond the width clears both result and carry
  always_comb begin
    if (!ctl.doImm && ctl.big && !ctl.exact && ctl.kind == SH_LSL)
      a_r9_lsl_beyond : assert (operand == '0 && !carryOut);
  end

endmodule

// File: rtl/second_operand_shifter.sv
module second_operand_shifter
  import opshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int REG_AMT_W = 8,
  localparam int AMT_W    = $clog2(DATA_W)
) (
  input  logic                 immSel,
  input  logic [IMM_W-1:0]     immVal,
  input  logic [ROT_W-1:0]     rotField,
  input  logic [DATA_W-1:0]    regVal,
  input  logic [1:0]           shType,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     amtField,
  input  logic [REG_AMT_W-1:0] amtByte,
  input  logic                 carryIn,
  output logic [DATA_W-1:0]    operand,
  output logic                 carryOut
);

  shCtrl_t          ctl;
  logic [AMT_W-1:0] amt;

  opshift_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W), .REG_AMT_W(REG_AMT_W)) u_ctrl (
    .immSel(immSel), .amtFromReg(amtFromReg), .shType(shType),
    .amtField(amtField), .amtByte(amtByte), .ctl(ctl), .amt(amt)
  );

  opshift_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .AMT_W(AMT_W)) u_dp (
    .ctl(ctl), .amt(amt), .immVal(immVal), .rotField(rotField),
    .regVal(regVal), .carryIn(carryIn), .operand(operand), .carryOut(carryOut)
  );

endmodule

// File: tb/second_operand_shifter_tb.sv
module second_operand_shifter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        immSel = 1'b0;
  logic [7:0]  immVal = '0;
  logic [3:0]  rotField = '0;
  logic [31:0] regVal = '0;
  logic [1:0]  shType = '0;
  logic        amtFromReg = 1'b0;
  logic [4:0]  amtField = '0;
  logic [7:0]  amtByte = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operand;
  logic        carryOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] op;
    logic        c;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #2 clk = ~clk;  // 250 MHz

  second_operand_shifter u_dut (
    .immSel(immSel), .immVal(immVal), .rotField(rotField), .regVal(regVal),
    .shType(shType), .amtFromReg(amtFromReg), .amtField(amtField),
    .amtByte(amtByte), .carryIn(carryIn), .operand(operand), .carryOut(carryOut)
  );

  // bit-serial reference built from the requirements
  function automatic logic [32:0] refModel(
    input logic is, input logic [7:0] iv, input logic [3:0] rf, input logic [31:0] rv,
    input logic [1:0] st, input logic fr, input logic [4:0] af, input logic [7:0] ab,
    input logic ci);
    logic [31:0] v;
    logic c;
    int n;
    if (is) begin
      v = {24'b0, iv};
      c = ci;
      for (int i = 0; i < 2 * int'(rf); i++) begin
        v = {v[0], v[31:1]};
        c = v[31];
      end
      return {c, v};
    end
    v = rv;
    c = ci;
    if (fr) n = int'(ab);
    else begin
      n = int'(af);
      if (n == 0) begin
        if (st == 2'd1 || st == 2'd2) n = 32;
        else if (st == 2'd3) return {rv[0], ci, rv[31:1]};
      end
    end
    for (int i = 0; i < n; i++) begin
      case (st)
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0]; v = v >> 1; end
        2'd2: begin c = v[0]; v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic drive(
    input logic is, input logic [7:0] iv, input logic [3:0] rf, input logic [31:0] rv,
    input logic [1:0] st, input logic fr, input logic [4:0] af, input logic [7:0] ab,
    input logic ci, input string tag);
    expItem_t e;
    logic [32:0] r;
    @(posedge clk);
    #1;
    immSel = is; immVal = iv; rotField = rf; regVal = rv; shType = st;
    amtFromReg = fr; amtField = af; amtByte = ab; carryIn = ci;
    r = refModel(is, iv, rf, rv, st, fr, af, ab, ci);
    e.op = r[31:0];
    e.c = r[32];
    e.tag = tag;
    scoreQ.push_back(e);
  endtask

  // monitor: compares away from the rising edge
  always @(negedge clk) begin
    if (!rst && scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      checks++;
      if (operand !== e.op || carryOut !== e.c) begin
        failures++;
        $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                 e.tag, operand, carryOut, e.op, e.c);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state with all inputs low
    drive(0, 8'h00, 4'h0, 32'h0, 2'd0, 0, 5'd0, 8'd0, 0, "R4 idle");
    // R1 / R2 immediate expansion
    drive(1, 8'hFF, 4'h0, 32'h1234, 2'd1, 1, 5'd3, 8'd7, 1, "R1 R2 no rotate");
    drive(1, 8'h3F, 4'hE, 32'hFFFF_FFFF, 2'd3, 0, 5'd0, 8'd0, 0, "R1 R2 rotate 28");
    drive(1, 8'h02, 4'h1, 32'h0, 2'd0, 0, 5'd9, 8'd0, 1, "R1 R2 rotate 2");
    drive(1, 8'h81, 4'hF, 32'hDEAD_BEEF, 2'd2, 1, 5'd1, 8'd200, 0, "R1 rotate 30");
    // R3 ordinary shifts
    drive(0, 8'h0, 4'h0, 32'd5, 2'd0, 0, 5'd3, 8'd0, 0, "R3 five times eight");
    drive(0, 8'h0, 4'h0, 32'h8000_0001, 2'd1, 0, 5'd1, 8'd0, 0, "R3 lsr 1");
    drive(0, 8'h0, 4'h0, 32'h8000_0010, 2'd2, 0, 5'd4, 8'd0, 0, "R3 asr 4");
    drive(0, 8'h0, 4'h0, 32'h0000_00F1, 2'd3, 0, 5'd4, 8'd0, 0, "R3 ror 4");
    // R4..R6 instruction-amount zero field
    drive(0, 8'h0, 4'h0, 32'hCAFE_F00D, 2'd0, 0, 5'd0, 8'd0, 1, "R4 lsl 0");
    drive(0, 8'h0, 4'h0, 32'h8000_0000, 2'd1, 0, 5'd0, 8'd0, 0, "R5 lsr 32");
    drive(0, 8'h0, 4'h0, 32'h8765_4321, 2'd2, 0, 5'd0, 8'd0, 0, "R5 asr 32");
    drive(0, 8'h0, 4'h0, 32'h0000_0003, 2'd3, 0, 5'd0, 8'd0, 1, "R6 rrx");
    drive(0, 8'h0, 4'h0, 32'h0000_0002, 2'd3, 0, 5'd0, 8'd0, 0, "R6 rrx carry 0");
    // R7..R11 register amount
    drive(0, 8'h0, 4'h0, 32'h0000_0010, 2'd0, 1, 5'd31, 8'd2, 0, "R7 field ignored");
    for (int k = 0; k < 4; k++)
      drive(0, 8'h0, 4'h0, 32'hF000_000F, 2'(k), 1, 5'd9, 8'd0, 1, "R8 zero amount");
    drive(0, 8'h0, 4'h0, 32'h0000_0001, 2'd0, 1, 5'd0, 8'd32, 0, "R9 lsl 32");
    drive(0, 8'h0, 4'h0, 32'hFFFF_FFFF, 2'd0, 1, 5'd0, 8'd33, 1, "R9 lsl 33");
    drive(0, 8'h0, 4'h0, 32'h8000_0000, 2'd1, 1, 5'd0, 8'd32, 0, "R9 lsr 32");
    drive(0, 8'h0, 4'h0, 32'hFFFF_FFFF, 2'd1, 1, 5'd0, 8'd255, 1, "R9 lsr 255");
    drive(0, 8'h0, 4'h0, 32'h8000_0000, 2'd2, 1, 5'd0, 8'd100, 0, "R10 asr 100 neg");
    drive(0, 8'h0, 4'h0, 32'h7FFF_FFFF, 2'd2, 1, 5'd0, 8'd40, 1, "R10 asr 40 pos");
    drive(0, 8'h0, 4'h0, 32'h8000_0001, 2'd3, 1, 5'd0, 8'd64, 0, "R11 ror 64");
    drive(0, 8'h0, 4'h0, 32'h0000_0006, 2'd3, 1, 5'd0, 8'd33, 0, "R11 ror 33");
    // random sweep
    for (int k = 0; k < 3000; k++)
      drive(1'($urandom), 8'($urandom), 4'($urandom), $urandom, 2'($urandom),
            1'($urandom), 5'($urandom), ($urandom % 3 == 0) ? 8'($urandom % 40) : 8'($urandom),
            1'($urandom), "R1 R3 R7 R9 R11 random");
    while (scoreQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule